// File: doc/BRIEF.md
# Half-to-Single Float Widening Converter

This unit turns a 16-bit IEEE binary16 value into the binary32 value that means exactly the same number. No rounding is ever needed, since every half-precision value can be written as a single-precision value. The unit handles every input class: signed zeros, subnormals, normals, infinities and NaNs. Each class keeps its sign. Half subnormals become single normals. A leading-one search finds the top fraction bit and a barrel shift moves it into place, so a result is ready in one clock.

A producer drives a half value with a valid strobe. One clock later the converter shows the single value, an output valid strobe and a flag. The flag marks a signalling NaN input. When no input is accepted, the result register keeps its last value.

Top module: `half_to_single_cvt`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `outValid`, `outSingle` and `outInvalid` are all zero.
- R2: `outValid` equals `inValid` one clock earlier. A strobe at the input gives exactly one output strobe, one clock later.
- R3: `outSingle` and `outInvalid` load only in a cycle where `inValid` is high. In any other cycle they hold, whatever `inHalf` carries.
- R4: A normal input (half exponent field, bits 14:10, between 1 and 30) gives exponent field plus 112 in output bits 30:23. The 10 fraction bits (9:0) appear at output bits 22:13, the bits below them are zero, and the sign moves from bit 15 to bit 31.
- R5: A zero exponent with a zero fraction gives a zero of the same sign: only output bit 31 may be set.
- R6: A subnormal input (zero exponent, nonzero fraction) whose highest set fraction bit is at position p gives output exponent 103+p. The fraction bits below position p are left-aligned at output bit 22, and the rest is zero.
- R7: An exponent field of 31 with a zero fraction gives a signed infinity: exponent 0xFF and fraction 0.
- R8: An exponent field of 31 with a nonzero fraction gives exponent 0xFF. The input fraction appears at bits 22:13, and bits 12:0 are all ones.
- R9: `outInvalid` is 1 exactly when the accepted input has exponent field 31, a nonzero fraction, and fraction bit 9 clear (a signalling NaN).
- R10: For every one of the 65536 input codes, the output equals the binary32 encoding of the value the input decodes to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input strobe; `inHalf` is accepted this cycle |
| inHalf | input | 16 | binary16 operand |
| outValid | output | 1 | Result strobe, one clock after `inValid` |
| outSingle | output | 32 | binary32 result |
| outInvalid | output | 1 | Accepted input was a signalling NaN |

## Verification
A fault in the leading-one search or the shift amount shows up at the next output strobe. It appears as a wrong exponent or a fraction shifted by one or more places, and only for subnormal inputs. An exhaustive sweep over all input codes therefore catches it within a single pass. A wrong capture enable shows up one clock after an idle cycle: the held result changes. A wrong valid register shows up as a missing strobe or an extra one, one clock after the input strobe. NaN padding and flag faults only appear for an all-ones exponent. The directed vectors cover both NaN kinds in both signs.

// File: rtl/hs_cvt_pkg.sv
package hs_cvt_pkg;
  parameter int HALF_EXP_W  = 5;
  parameter int HALF_FRAC_W = 10;
  parameter int SGL_EXP_W   = 8;
  parameter int SGL_FRAC_W  = 23;

  localparam int HALF_W    = 1 + HALF_EXP_W + HALF_FRAC_W;
  localparam int SGL_W     = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int HALF_BIAS = (1 << (HALF_EXP_W - 1)) - 1;
  localparam int SGL_BIAS  = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int PAD_W     = SGL_FRAC_W - HALF_FRAC_W;
  localparam int REBIAS    = SGL_BIAS - HALF_BIAS;
  localparam int SUB_BASE  = SGL_BIAS - (HALF_BIAS - 1) - HALF_FRAC_W;
  localparam int IDX_W     = $clog2(HALF_FRAC_W + 1);

  typedef struct packed {
    logic capture;
  } ctrlStrobeT;
endpackage

// File: rtl/hs_lead_one.sv
module hs_lead_one #(
  parameter int W = 10,
  localparam int IW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  logic [W-1:0] hit;

  // one-hot marker of the highest set bit
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : gHit
      if (g == W - 1) begin : gTop
        assign hit[g] = vec[g];
      end else begin : gLow
        assign hit[g] = vec[g] & ~(|vec[W-1:g+1]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) idx = IW'(i);
    end
  end

  assign found = |vec;
endmodule

// File: rtl/hs_control.sv
module hs_control
  import hs_cvt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output ctrlStrobeT strobes,
  output logic       outValid
);
  assign strobes.capture = inValid;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/hs_datapath.sv
module hs_datapath
  import hs_cvt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [HALF_W-1:0] inHalf,
  output logic [SGL_W-1:0]  outSingle,
  output logic              outInvalid
);
  localparam logic [HALF_EXP_W-1:0] HEXP_ONES = '1;
  localparam logic [SGL_EXP_W-1:0]  SEXP_ONES = '1;

  logic                   sgn;
  logic [HALF_EXP_W-1:0]  hExp;
  logic [HALF_FRAC_W-1:0] hFrac;
  logic [IDX_W-1:0]       leadIdx;
  logic                   leadFound;
  logic [IDX_W-1:0]       shAmt;
  logic [HALF_FRAC_W:0]   shifted;
  logic [SGL_EXP_W-1:0]   wExp;
  logic [SGL_FRAC_W-1:0]  wFrac;
  logic                   sigNan;

  assign sgn   = inHalf[HALF_W-1];
  assign hExp  = inHalf[HALF_W-2 -: HALF_EXP_W];
  assign hFrac = inHalf[HALF_FRAC_W-1:0];

  hs_lead_one #(.W(HALF_FRAC_W)) leadOne_i (
    .vec  (hFrac),
    .idx  (leadIdx),
    .found(leadFound)
  );

  assign shAmt   = IDX_W'(HALF_FRAC_W) - leadIdx;
  assign shifted = {1'b0, hFrac} << shAmt;

  always_comb begin
    wExp  = '0;
    wFrac = '0;
    if (hExp == '0) begin
      if (leadFound) begin
        wExp  = SGL_EXP_W'(SUB_BASE) + SGL_EXP_W'(leadIdx);
        wFrac = {shifted[HALF_FRAC_W-1:0], {PAD_W{1'b0}}};
      end
    end else if (hExp == HEXP_ONES) begin
      wExp  = SEXP_ONES;
      wFrac = {hFrac, {PAD_W{leadFound}}};
    end else begin
      wExp  = SGL_EXP_W'(hExp) + SGL_EXP_W'(REBIAS);
      wFrac = {hFrac, {PAD_W{1'b0}}};
    end
  end

  assign sigNan = (hExp == HEXP_ONES) && leadFound && !hFrac[HALF_FRAC_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSingle  <= '0;
      outInvalid <= 1'b0;
    end else if (strobes.capture) begin
      outSingle  <= {sgn, wExp, wFrac};
      outInvalid <= sigNan;
    end
  end

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(outSingle) && $stable(outInvalid));
  a_r9_flag_only_on_nan: assert property (@(posedge clk) disable iff (!rstN)
    outInvalid |-> (outSingle[SGL_W-2 -: SGL_EXP_W] == SEXP_ONES)
                   && !outSingle[SGL_FRAC_W-1]);
  a_r8_nan_padding: assert property (@(posedge clk) disable iff (!rstN)
    (outSingle[SGL_W-2 -: SGL_EXP_W] == SEXP_ONES) && (outSingle[SGL_FRAC_W-1:0] != '0)
    |-> (outSingle[PAD_W-1:0] == '1));
  a_r6_subnormal_range: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && (hExp == '0) && (hFrac != '0)
    |=> (outSingle[SGL_W-2 -: SGL_EXP_W] >= SGL_EXP_W'(SUB_BASE))
        && (outSingle[SGL_W-2 -: SGL_EXP_W] < SGL_EXP_W'(SUB_BASE + HALF_FRAC_W)));
  a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> outSingle[SGL_W-1] == $past(inHalf[HALF_W-1]));
endmodule

// File: rtl/half_to_single_cvt.sv
module half_to_single_cvt
  import hs_cvt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [15:0] inHalf,
  output logic        outValid,
  output logic [31:0] outSingle,
  output logic        outInvalid
);
  ctrlStrobeT strobes;

  hs_control control_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  hs_datapath datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inHalf    (inHalf),
    .outSingle (outSingle),
    .outInvalid(outInvalid)
  );
endmodule

// File: tb/half_to_single_cvt_tb_top.sv
module half_to_single_cvt_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inHalf = '0;
  logic        outValid;
  logic [31:0] outSingle;
  logic        outInvalid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  half_to_single_cvt dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inHalf(inHalf),
    .outValid(outValid), .outSingle(outSingle), .outInvalid(outInvalid)
  );

  localparam int NV = 14;
  localparam logic [15:0] vHalf [NV] = '{
    16'h0000, 16'h8000,                       // R5
    16'h3C00, 16'hC000, 16'h7BFF, 16'h0400,   // R4
    16'h0001, 16'h8200, 16'h03FF, 16'h0155,   // R6
    16'h7C00, 16'hFC00,                       // R7
    16'h7E00, 16'h7C01                        // R8, R9
  };
  localparam logic [31:0] vSgl [NV] = '{
    32'h00000000, 32'h80000000,
    32'h3F800000, 32'hC0000000, 32'h477FE000, 32'h38800000,
    32'h33800000, 32'hB8000000, 32'h387FC000, 32'h37AA8000,
    32'h7F800000, 32'hFF800000,
    32'h7FC01FFF, 32'h7F803FFF
  };
  localparam logic vInv [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1
  };
  localparam string vTag [NV] = '{
    "R5", "R5", "R4", "R4", "R4", "R4", "R6",
    "R6", "R6", "R6", "R7", "R7", "R8", "R9"
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // reference model: decode to a real value, then re-encode via double bits
  function automatic logic [31:0] refModel(input logic [15:0] h);
    logic       s;
    int         e, f;
    real        r;
    logic [63:0] d;
    logic [7:0] oe;
    s = h[15];
    e = int'(h[14:10]);
    f = int'(h[9:0]);
    if (e == 31) begin
      if (f == 0) return {s, 8'hFF, 23'h0};
      return {s, 8'hFF, h[9:0], 13'h1FFF};
    end
    if (e == 0) r = real'(f) * (2.0 ** (-24.0));
    else        r = real'(1024 + f) * (2.0 ** real'(e - 25));
    if (r == 0.0) return {s, 31'h0};
    d  = $realtobits(r);
    oe = 8'(int'(d[62:52]) - 1023 + 127);
    return {s, oe, d[51:29]};
  endfunction

  function automatic logic refInvalid(input logic [15:0] h);
    return (h[14:10] == 5'h1F) && (h[9:0] != 0) && !h[9];
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] held;
    logic [15:0] prevH;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid == 0 && outSingle == 0 && outInvalid == 0, "R1 in reset",
          {outValid, outInvalid, outSingle[29:0]}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 0 && outSingle == 0 && outInvalid == 0, "R1 after reset",
          {outValid, outInvalid, outSingle[29:0]}, 32'h0);

    // directed vector table
    for (int i = 0; i < NV; i++) begin
      inValid = 1'b1;
      inHalf  = vHalf[i];
      @(negedge clk);
      inValid = 1'b0;
      check(outSingle == vSgl[i], vTag[i], outSingle, vSgl[i]);
      check(outInvalid == vInv[i], "R9 flag", 32'(outInvalid), 32'(vInv[i]));
      check(outValid == 1'b1, "R2 strobe", 32'(outValid), 32'h1);
      @(negedge clk);
      check(outValid == 1'b0, "R2 single strobe", 32'(outValid), 32'h0);
    end

    // R9: signalling NaN with sign set, and quiet NaN leaves flag low
    inValid = 1'b1; inHalf = 16'hFDFF;
    @(negedge clk);
    check(outSingle == 32'hFFBFFFFF, "R8 negative sNaN", outSingle, 32'hFFBFFFFF);
    check(outInvalid == 1'b1, "R9 sNaN flag", 32'(outInvalid), 32'h1);
    inHalf = 16'hFE01;
    @(negedge clk);
    check(outInvalid == 1'b0, "R9 qNaN no flag", 32'(outInvalid), 32'h0);
    check(outSingle == 32'hFFC03FFF, "R8 qNaN payload", outSingle, 32'hFFC03FFF);

    // R3: idle cycles with changing input must not disturb the result
    inValid = 1'b0;
    held = outSingle;
    for (int k = 0; k < 4; k++) begin
      inHalf = 16'h1234 + 16'(k * 977);
      @(negedge clk);
      check(outSingle == held, "R3 hold", outSingle, held);
      check(outValid == 1'b0, "R2 idle", 32'(outValid), 32'h0);
    end

    // R10: exhaustive pipelined sweep, one code per clock
    prevH = '0;
    for (int i = 0; i <= 65536; i++) begin
      if (i < 65536) begin
        inValid = 1'b1;
        inHalf  = 16'(i);
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
      if (i < 65536) begin
        check(outSingle == refModel(16'(i)), "R10 sweep", outSingle, refModel(16'(i)));
        check(outInvalid == refInvalid(16'(i)), "R10 flag", 32'(outInvalid),
              32'(refInvalid(16'(i))));
      end
      prevH = 16'(i);
    end
    check(outValid == 1'b0, "R2 end of stream", 32'(outValid), 32'h0);

    // R1: reset mid-run clears the outputs
    rstN = 1'b0;
    @(negedge clk);
    check(outValid == 0 && outSingle == 0 && outInvalid == 0, "R1 re-reset",
          {outValid, outInvalid, outSingle[29:0]}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule